// File: doc/BRIEF.md
# Static memory strobe generator

This block drives the control pins of one static memory chip select. An internal master hands it a request: read or write, a word address, a four-bit byte-enable mask and a burst length. The block then produces the chip select, write enable, output enable, four byte-lane strobes and the address of the current beat. Each beat is held for a programmable number of wait clocks, and the final clock of a beat is flagged so that the master can move data on that edge.

Three configuration inputs set how the pins behave. The lane-mode bit chooses between two kinds of memory. In the first, the lanes act as per-byte write strobes, which suits byte-wide parts. In the second, the lanes act as upper/lower byte selects, which suits 16-bit parts. The polarity bit sets the active level of the chip select. The page bit lets consecutive beats inside one aligned four-word page share a single chip-select assertion, and every beat after the first in such a run uses a shorter wait count. Every other access is followed by one clock with all pins idle. A burst that runs past a page edge is split, and the next page begins with a fresh assertion and the full wait count. Configuration is expected to stay stable while an access is in flight.

Top module: `smc_strobe_gen`

## Requirements
- R1: Out of reset and whenever no access is in progress, req_ready_o is 1, cs_o sits at its inactive level, and we_no, oe_no and all of lane_no are 1.
- R2: cs_o is active high when cfg_cs_high_i is 1 and active low when it is 0. The inactive level is the opposite one, and it follows cfg_cs_high_i even while idle.
- R3: With cfg_lane_state_i = 0, a read drives oe_no low and holds all four lane_no bits high.
- R4: With cfg_lane_state_i = 0, a write drives lane_no low only on lanes whose req_be_i bit is 1 (lane_no = ~be), and we_no stays 1 for the whole access.
- R5: With cfg_lane_state_i = 1, reads and writes both drive lane_no = ~be. A write also drives we_no low, and a read drives oe_no low with we_no high.
- R6: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. The first beat of a page starts on the next clock and lasts cfg_wait_first_i+1 clocks, and beat_done_o is 1 only on its last clock.
- R7: With cfg_page_en_i = 0, every beat gets its own chip-select assertion, and exactly one clock with all pins inactive follows it. addr_o advances by one per beat.
- R8: With cfg_page_en_i = 1, beats whose addresses share the same upper bits (addr[ADDR_W-1:2]) keep cs_o active with no idle clock between them. Only addr_o[1:0] advances, and each such later beat lasts cfg_wait_page_i+1 clocks.
- R9: A page burst whose next address has addr[1:0] = 0 ends the current assertion. One inactive clock follows, and the next page begins with a first-beat wait count.
- R10: req_len_i gives beats minus one. After the last beat, one inactive clock follows, and then req_ready_o returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_lane_state_i | input | 1 | 0: lanes are write strobes; 1: lanes are byte selects |
| cfg_cs_high_i | input | 1 | Chip-select active level (1 = high) |
| cfg_page_en_i | input | 1 | Enable page bursts within a four-word page |
| cfg_wait_first_i | input | WAIT_W | Wait clocks for the first beat of a page |
| cfg_wait_page_i | input | WAIT_W | Wait clocks for later beats inside a page |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Start word address |
| req_be_i | input | LANES | Active byte lanes |
| req_len_i | input | LEN_W | Number of beats minus one |
| req_ready_o | output | 1 | Idle and able to accept a request |
| beat_done_o | output | 1 | Last clock of the current beat |
| addr_o | output | ADDR_W | Address of the current beat |
| cs_o | output | 1 | Chip select |
| we_no | output | 1 | Write enable, active low |
| oe_no | output | 1 | Output enable, active low |
| lane_no | output | LANES | Byte-lane strobes, active low |

## Verification
The checker holds on every cycle the pin relations that need no history. All pins are idle whenever the chip select is off, read and write enables are never low together, lanes stay high on reads in write-strobe mode, and write enable is parked in that mode. It also checks the edge rules: a non-page beat or a beat ending on the last word of a page is always followed by a released chip select, and an address change under a held chip select moves only the low two bits by one. Beat lengths, which wait count applies to each beat, the exact lane patterns for a given mask, and the return of ready after a burst depend on the request and configuration values. Only the bench's directed scenarios, with expected cycle-by-cycle traces, can show these.

// File: rtl/smc_strobe_pkg.sv
package smc_strobe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_GAP    = 2'd2
  } smc_state_e;

  // words per asynchronous page, as address bits
  localparam int unsigned PAGE_W = 2;
endpackage

// File: rtl/smc_beat_ctrl.sv
module smc_beat_ctrl
  import smc_strobe_pkg::*;
#(
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              page_en_i,
  input  logic              page_last_i,
  input  logic [WAIT_W-1:0] wait_first_i,
  input  logic [WAIT_W-1:0] wait_page_i,
  output smc_state_e        state_o,
  output logic              beat_end_o,
  output logic              idle_o
);
  localparam logic [WAIT_W-1:0] W_ONE = WAIT_W'(1);
  localparam logic [LEN_W-1:0]  L_ONE = LEN_W'(1);

  smc_state_e        state_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic [LEN_W-1:0]  remain_q;
  logic              more_q;   // split pending: another page follows the gap

  assign beat_end_o = (state_q == ST_ACCESS) && (wcnt_q == '0);
  assign idle_o     = (state_q == ST_IDLE);
  assign state_o    = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wcnt_q   <= '0;
      remain_q <= '0;
      more_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_ACCESS;
            wcnt_q   <= wait_first_i;
            remain_q <= len_i;
            more_q   <= 1'b0;
          end
        end
        ST_ACCESS: begin
          if (wcnt_q != '0) begin
            wcnt_q <= wcnt_q - W_ONE;
          end else if (remain_q == '0) begin
            state_q <= ST_GAP;
            more_q  <= 1'b0;
          end else begin
            remain_q <= remain_q - L_ONE;
            if (page_en_i && !page_last_i) begin
              wcnt_q <= wait_page_i;
            end else begin
              state_q <= ST_GAP;
              more_q  <= 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (more_q) begin
            state_q <= ST_ACCESS;
            wcnt_q  <= wait_first_i;
            more_q  <= 1'b0;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smc_addr_step.sv
module smc_addr_step
  import smc_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              page_last_o
);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_addr_i;
    else if (step_i) addr_q <= addr_q + A_ONE;
  end

  assign addr_o      = addr_q;
  assign page_last_o = &addr_q[PAGE_W-1:0];
endmodule

// File: rtl/smc_lane_decode.sv
module smc_lane_decode #(
  parameter int unsigned LANES = 4
) (
  input  logic             active_i,
  input  logic             write_i,
  input  logic [LANES-1:0] be_i,
  input  logic             lane_state_i,
  input  logic             cs_high_i,
  output logic             cs_o,
  output logic             we_no,
  output logic             oe_no,
  output logic [LANES-1:0] lane_no
);
  always_comb begin
    cs_o    = active_i ? cs_high_i : ~cs_high_i;
    we_no   = 1'b1;
    oe_no   = 1'b1;
    lane_no = '1;
    if (active_i) begin
      if (write_i) begin
        we_no   = ~lane_state_i;  // write-strobe mode parks WE
        lane_no = ~be_i;
      end else begin
        oe_no   = 1'b0;
        lane_no = lane_state_i ? ~be_i : '1;
      end
    end
  end
endmodule

// File: rtl/smc_strobe_gen.sv
module smc_strobe_gen
  import smc_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LANES  = 4,
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_lane_state_i,
  input  logic              cfg_cs_high_i,
  input  logic              cfg_page_en_i,
  input  logic [WAIT_W-1:0] cfg_wait_first_i,
  input  logic [WAIT_W-1:0] cfg_wait_page_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LANES-1:0]  req_be_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              req_ready_o,
  output logic              beat_done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cs_o,
  output logic              we_no,
  output logic              oe_no,
  output logic [LANES-1:0]  lane_no
);
  smc_state_e       state;
  logic             idle, start, beat_end, page_last;
  logic             write_q;
  logic [LANES-1:0] be_q;

  assign start = req_valid_i && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_q <= 1'b0;
      be_q    <= '0;
    end else if (start) begin
      write_q <= req_write_i;
      be_q    <= req_be_i;
    end
  end

  smc_beat_ctrl #(.WAIT_W(WAIT_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .len_i        (req_len_i),
    .page_en_i    (cfg_page_en_i),
    .page_last_i  (page_last),
    .wait_first_i (cfg_wait_first_i),
    .wait_page_i  (cfg_wait_page_i),
    .state_o      (state),
    .beat_end_o   (beat_end),
    .idle_o       (idle)
  );

  smc_addr_step #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .load_addr_i (req_addr_i),
    .step_i      (beat_end),
    .addr_o      (addr_o),
    .page_last_o (page_last)
  );

  smc_lane_decode #(.LANES(LANES)) u_lanes (
    .active_i     (state == ST_ACCESS),
    .write_i      (write_q),
    .be_i         (be_q),
    .lane_state_i (cfg_lane_state_i),
    .cs_high_i    (cfg_cs_high_i),
    .cs_o         (cs_o),
    .we_no        (we_no),
    .oe_no        (oe_no),
    .lane_no      (lane_no)
  );

  assign req_ready_o = idle;
  assign beat_done_o = beat_end;
endmodule

// File: rtl/smc_strobe_chk.sv
module smc_strobe_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LANES  = 4,
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned LEN_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_lane_state_i,
  input logic              cfg_cs_high_i,
  input logic              cfg_page_en_i,
  input logic [WAIT_W-1:0] cfg_wait_first_i,
  input logic [WAIT_W-1:0] cfg_wait_page_i,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [LANES-1:0]  req_be_i,
  input logic [LEN_W-1:0]  req_len_i,
  input logic              req_ready_o,
  input logic              beat_done_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              cs_o,
  input logic              we_no,
  input logic              oe_no,
  input logic [LANES-1:0]  lane_no
);
  logic cs_on;
  assign cs_on = (cs_o == cfg_cs_high_i);

  a_r1_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_on |-> (we_no && oe_no && (&lane_no)));

  a_r1_ready_means_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !cs_on);

  a_r3_read_lanes_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_on && !oe_no && !cfg_lane_state_i) |-> (&lane_no));

  a_r4_we_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_lane_state_i |-> we_no);

  a_r5_rd_wr_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> we_no);

  a_r6_done_under_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_done_o |-> cs_on);

  a_r7_gap_after_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(beat_done_o) && !$past(cfg_page_en_i)) |-> !cs_on);

  a_r8_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_on && $past(cs_on) && (addr_o != $past(addr_o))) |->
      ((addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])) &&
       (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1)));

  a_r9_page_edge_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(beat_done_o) && (&$past(addr_o[1:0]))) |-> !cs_on);
endmodule

bind smc_strobe_gen smc_strobe_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .WAIT_W(WAIT_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/smc_strobe_gen_test.sv
module smc_strobe_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ls = 1'b0, cfg_csh = 1'b0, cfg_page = 1'b0;
  logic [3:0]  cfg_wf = 4'd0, cfg_wp = 4'd0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [3:0]  req_len = '0;
  logic        ready, done, cs, we_n, oe_n;
  logic [23:0] addr;
  logic [3:0]  lane_n;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  smc_strobe_gen uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_lane_state_i(cfg_ls), .cfg_cs_high_i(cfg_csh), .cfg_page_en_i(cfg_page),
    .cfg_wait_first_i(cfg_wf), .cfg_wait_page_i(cfg_wp),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_be_i(req_be), .req_len_i(req_len),
    .req_ready_o(ready), .beat_done_o(done), .addr_o(addr),
    .cs_o(cs), .we_no(we_n), .oe_no(oe_n), .lane_no(lane_n)
  );

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s t=%0t pins{cs,we,oe,lane,done,rdy} got=%b exp=%b", tag, $time, got, exp);
    end
  endtask

  task automatic check_addr(input string tag, input logic [23:0] exp);
    checks++;
    if (addr !== exp) begin
      failures++;
      $display("FAIL %s t=%0t addr got=%h exp=%h", tag, $time, addr, exp);
    end
  endtask

  task automatic chk_off(input string tag, input logic rdy);
    check(tag, {cs, we_n, oe_n, lane_n, done, ready}, {~cfg_csh, 1'b1, 1'b1, 4'hF, 1'b0, rdy});
  endtask

  task automatic chk_on(input string tag, input bit wr, input logic [3:0] be,
                        input logic [23:0] a, input bit last);
    logic [3:0] el;
    el = (!wr && !cfg_ls) ? 4'hF : ~be;
    check(tag, {cs, we_n, oe_n, lane_n, done, ready},
          {cfg_csh, !(wr && cfg_ls), wr, el, last, 1'b0});
    check_addr(tag, a);
  endtask

  // drive one request and follow its expected trace at each falling edge
  task automatic run_burst(input bit wr, input logic [23:0] a0, input logic [3:0] be,
                           input int len, input string tag, input string gtag);
    logic [23:0] a;
    int w;
    bit grp;
    a = a0;
    req_valid = 1'b1; req_write = wr; req_addr = a0; req_be = be; req_len = 4'(len);
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b <= len; b++) begin
      grp = (b == 0) || !cfg_page || (a[1:0] == 2'd0);
      if (b != 0 && grp) begin
        chk_off(gtag, 1'b0);
        @(negedge clk);
      end
      w = grp ? int'(cfg_wf) : int'(cfg_wp);
      for (int c = 0; c <= w; c++) begin
        chk_on(tag, wr, be, a, c == w);
        @(negedge clk);
      end
      a = a + 24'd1;
    end
    chk_off(gtag, 1'b0);
    @(negedge clk);
    chk_off("R10", 1'b1);
  endtask

  task automatic t_reset();
    chk_off("R1", 1'b1);
    cfg_csh = 1'b1; #1;
    chk_off("R2", 1'b1);
    cfg_csh = 1'b0; #1;
    chk_off("R2", 1'b1);
  endtask

  task automatic t_ls0();
    cfg_ls = 0; cfg_page = 0; cfg_wf = 4'd2;
    run_burst(1'b0, 24'h000010, 4'hF, 0, "R3", "R7");
    cfg_wf = 4'd1;
    run_burst(1'b1, 24'h000020, 4'b0101, 0, "R4", "R7");
  endtask

  task automatic t_ls1();
    cfg_ls = 1; cfg_csh = 1; cfg_wf = 4'd1;
    run_burst(1'b0, 24'h000031, 4'b0011, 0, "R5", "R7");
    run_burst(1'b1, 24'h000040, 4'b1100, 0, "R5", "R7");
    run_burst(1'b0, 24'h000041, 4'hF, 0, "R2", "R7");
    cfg_csh = 0;
  endtask

  task automatic t_wait();
    cfg_ls = 0; cfg_wf = 4'd5;
    run_burst(1'b0, 24'h000050, 4'hF, 0, "R6", "R7");
    cfg_wf = 4'd0;
    run_burst(1'b1, 24'h000051, 4'b1000, 0, "R6", "R7");
  endtask

  task automatic t_nopage();
    cfg_page = 0; cfg_wf = 4'd1; cfg_wp = 4'd0;
    run_burst(1'b0, 24'h000102, 4'hF, 2, "R7", "R7");
  endtask

  task automatic t_page();
    cfg_page = 1; cfg_ls = 1; cfg_wf = 4'd3; cfg_wp = 4'd1;
    run_burst(1'b0, 24'h000100, 4'hF, 3, "R8", "R9");
  endtask

  task automatic t_split();
    cfg_page = 1; cfg_ls = 0; cfg_wf = 4'd2; cfg_wp = 4'd0;
    run_burst(1'b0, 24'h0001FE, 4'hF, 4, "R9", "R9");
    run_burst(1'b1, 24'h000200, 4'b0110, 5, "R10", "R9");
    cfg_page = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ls0();
    t_ls1();
    t_wait();
    t_nopage();
    t_page();
    t_split();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule